// File: doc/BRIEF.md
# Anode Wire-Group Track Stub Finder

This block looks at the anode hit bits of a six-layer wire chamber, one full set per bunch crossing, and finds short track segments ("stubs") that point back to the collision region. For every wire group on the middle reference layer it counts how many layers have a hit inside a fixed slanted window around that group. A low threshold raises a pre-trigger flag. A higher threshold turns a window into a confirmed stub. Each crossing, the two best stubs are reported, ranked by their layer count.

Every input hit is held for a programmable number of crossings, so layers that fire one or two crossings apart still combine into one segment. The thresholds and the hold length arrive as static inputs from the surrounding control logic. Each reported stub carries its key wire group and its layer count. A shared crossing number tells which input crossing the result belongs to.

Top module: `awg_stub_finder`

## Requirements
- R1: While reset is asserted, and after it is released until new hits arrive, every output is zero and no stub is valid, whatever the hit inputs carry.
- R2: For key wire group k, layer L counts as hit when any stretched bit of that layer lies in its window. The windows are: layer 0 k-2..k, layer 1 k-1..k, layer 2 k only, layer 3 k..k+1, layer 4 k..k+2, layer 5 k..k+2. Layer L, wire w is input bit L*NWG+w. Results for hits applied in crossing c appear on the outputs two crossings later.
- R3: Window columns below 0 or above NWG-1 are treated as empty. A track on wire 0 or wire NWG-1 still yields a full six-layer count.
- R4: A stub is valid only when its layer count is at least the confirm threshold, at least the pre-trigger threshold, and at least 1.
- R5: The pre-trigger flag is high exactly when some key has a layer count of at least the pre-trigger threshold.
- R6: Stub 0 is the qualifying key with the highest layer count. On a tie, the lowest key wins.
- R7: Stub 1 is chosen by the same rule, but only among qualifying keys more than 2 wire groups away from stub 0. A key 3 away is allowed. If no such key exists, stub 1 is invalid. Stub 1 is never valid without stub 0.
- R8: A hit applied in crossing c counts in crossings c+1 through c+S, where S is the stretch input (S=0 acts as 1). A stretch of 3 merges layers arriving two crossings apart. A stretch of 1 does not.
- R9: The crossing number output equals the number of the latest input crossing that fed the result. It advances by one per crossing, so two results whose inputs are 5 crossings apart differ by 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hits_i | input | 6*NWG | Hit bits, layer L wire w at bit L*NWG+w |
| pretrig_thr_i | input | 3 | Pre-trigger layer threshold |
| confirm_thr_i | input | 3 | Confirm layer threshold |
| stretch_i | input | SW | Hit hold length in crossings |
| pretrig_o | output | 1 | Some key reached the pre-trigger threshold |
| stub0_valid_o | output | 1 | Best stub present |
| stub0_key_o | output | KW | Best stub key wire group |
| stub0_nlay_o | output | 3 | Best stub layer count |
| stub1_valid_o | output | 1 | Second stub present |
| stub1_key_o | output | KW | Second stub key wire group |
| stub1_nlay_o | output | 3 | Second stub layer count |
| bx_o | output | BXW | Crossing number of the result |

## Verification
The bench drives tracks that sit right on both chamber edges. A design that wraps or drops out-of-range window columns loses layers there or invents stubs on the far side. It also drives a track slanted against the envelope, which must stay below confirm, and two tracks tied in layer count, where picking the higher key swaps the stubs.

The exclusion zone is tested twice. A straight track has strong three-layer neighbours within two groups, and these must not become stub 1. A second segment exactly three groups away must be accepted, which catches an off-by-one in the distance test.

For the stretch, hits are split across crossings two apart. With a hold of 3 they must merge in exactly one result crossing, and with a hold of 1 they must never merge. The pre-trigger gate on confirmation is also checked, and so is the spacing of crossing numbers.

// File: rtl/awg_stub_pkg.sv
package awg_stub_pkg;
  localparam int NLAYER = 6;
  localparam int CNTW   = 3;

  // Lower edge of the collision envelope for a layer, relative to the key.
  function automatic int win_lo(input int layer);
    case (layer)
      0:       return -2;
      1:       return -1;
      default: return 0;
    endcase
  endfunction

  // Upper edge of the collision envelope for a layer, relative to the key.
  function automatic int win_hi(input int layer);
    case (layer)
      3:       return 1;
      4, 5:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/awg_hit_stretch.sv
module awg_hit_stretch #(
  parameter int NBIT = 672,
  parameter int SW   = 2
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBIT-1:0] hit_i,
  input  logic [SW-1:0]   len_i,
  output logic [NBIT-1:0] str_o
);
  logic [SW-1:0] len_eff;
  assign len_eff = (len_i == '0) ? SW'(1) : len_i;

  for (genvar j = 0; j < NBIT; j++) begin : g_bit
    logic [SW-1:0] cnt_q, cnt_d;

    always_comb begin
      cnt_d = cnt_q;
      if (hit_i[j])            cnt_d = len_eff;
      else if (cnt_q != '0)    cnt_d = cnt_q - SW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign str_o[j] = (cnt_q != '0);

    assert_hit_seen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i[j] |=> str_o[j]);
  end
endmodule

// File: rtl/awg_pattern_count.sv
module awg_pattern_count
  import awg_stub_pkg::*;
#(
  parameter int NWG = 112
)(
  input  logic [NLAYER*NWG-1:0] str_i,
  output logic [NWG*CNTW-1:0]   cnt_o
);
  for (genvar k = 0; k < NWG; k++) begin : g_key
    logic [CNTW-1:0] sum;

    always_comb begin
      logic any;
      int   col;
      sum = '0;
      for (int l = 0; l < NLAYER; l++) begin
        any = 1'b0;
        for (int o = win_lo(l); o <= win_hi(l); o++) begin
          col = k + o;
          if (col >= 0 && col < NWG) any = any | str_i[l*NWG + col];
        end
        sum = sum + CNTW'(any);
      end
    end

    assign cnt_o[k*CNTW +: CNTW] = sum;
  end
endmodule

// File: rtl/awg_best_two.sv
module awg_best_two
  import awg_stub_pkg::*;
#(
  parameter int NWG = 112,
  parameter int KW  = 7
)(
  input  logic [NWG*CNTW-1:0] cnt_i,
  input  logic [CNTW-1:0]     stub_thr_i,
  input  logic [CNTW-1:0]     pre_thr_i,
  output logic                pre_o,
  output logic                v0_o,
  output logic [KW-1:0]       k0_o,
  output logic [CNTW-1:0]     n0_o,
  output logic                v1_o,
  output logic [KW-1:0]       k1_o,
  output logic [CNTW-1:0]     n1_o
);
  always_comb begin
    logic [CNTW-1:0] c;
    pre_o = 1'b0;
    v0_o  = 1'b0;
    k0_o  = '0;
    n0_o  = '0;
    for (int k = 0; k < NWG; k++) begin
      c = cnt_i[k*CNTW +: CNTW];
      if (c >= pre_thr_i) pre_o = 1'b1;
      if (c >= stub_thr_i && (!v0_o || c > n0_o)) begin
        v0_o = 1'b1;
        k0_o = KW'(k);
        n0_o = c;
      end
    end
  end

  always_comb begin
    logic [CNTW-1:0] c;
    logic            far;
    v1_o = 1'b0;
    k1_o = '0;
    n1_o = '0;
    for (int k = 0; k < NWG; k++) begin
      c   = cnt_i[k*CNTW +: CNTW];
      far = (k > int'(k0_o) + 2) || (k + 2 < int'(k0_o));
      if (v0_o && far && c >= stub_thr_i && (!v1_o || c > n1_o)) begin
        v1_o = 1'b1;
        k1_o = KW'(k);
        n1_o = c;
      end
    end
  end
endmodule

// File: rtl/awg_stub_finder.sv
module awg_stub_finder
  import awg_stub_pkg::*;
#(
  parameter  int NWG = 112,
  parameter  int SW  = 2,
  parameter  int BXW = 12,
  localparam int KW  = $clog2(NWG)
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NLAYER*NWG-1:0] hits_i,
  input  logic [CNTW-1:0]       pretrig_thr_i,
  input  logic [CNTW-1:0]       confirm_thr_i,
  input  logic [SW-1:0]         stretch_i,
  output logic                  pretrig_o,
  output logic                  stub0_valid_o,
  output logic [KW-1:0]         stub0_key_o,
  output logic [CNTW-1:0]       stub0_nlay_o,
  output logic                  stub1_valid_o,
  output logic [KW-1:0]         stub1_key_o,
  output logic [CNTW-1:0]       stub1_nlay_o,
  output logic [BXW-1:0]        bx_o
);
  // Reset: asserted at once, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // Stage 1: hold each hit for the programmed number of crossings.
  logic [NLAYER*NWG-1:0] str;
  awg_hit_stretch #(.NBIT(NLAYER*NWG), .SW(SW)) u_stretch (
    .clk(clk), .rst_n(rst_int_n), .hit_i(hits_i), .len_i(stretch_i), .str_o(str)
  );

  // Crossing counter and the tag of the crossing now held in stage 1.
  logic [BXW-1:0] bx_q, bx_d, bx_in_q;
  assign bx_d = bx_q + BXW'(1);
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bx_q    <= '0;
      bx_in_q <= '0;
    end else begin
      bx_q    <= bx_d;
      bx_in_q <= bx_q;
    end
  end

  // Envelope layer counts for every key.
  logic [NWG*CNTW-1:0] cnt;
  awg_pattern_count #(.NWG(NWG)) u_count (.str_i(str), .cnt_o(cnt));

  // A stub needs both thresholds and at least one layer.
  logic [CNTW-1:0] thr_max, stub_thr;
  assign thr_max  = (confirm_thr_i > pretrig_thr_i) ? confirm_thr_i : pretrig_thr_i;
  assign stub_thr = (thr_max == '0) ? CNTW'(1) : thr_max;

  logic            s_pre, s_v0, s_v1;
  logic [KW-1:0]   s_k0, s_k1;
  logic [CNTW-1:0] s_n0, s_n1;
  awg_best_two #(.NWG(NWG), .KW(KW)) u_select (
    .cnt_i(cnt), .stub_thr_i(stub_thr), .pre_thr_i(pretrig_thr_i),
    .pre_o(s_pre), .v0_o(s_v0), .k0_o(s_k0), .n0_o(s_n0),
    .v1_o(s_v1), .k1_o(s_k1), .n1_o(s_n1)
  );

  // Stage 2: output registers.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pretrig_o     <= 1'b0;
      stub0_valid_o <= 1'b0;
      stub0_key_o   <= '0;
      stub0_nlay_o  <= '0;
      stub1_valid_o <= 1'b0;
      stub1_key_o   <= '0;
      stub1_nlay_o  <= '0;
      bx_o          <= '0;
    end else begin
      pretrig_o     <= s_pre;
      stub0_valid_o <= s_v0;
      stub0_key_o   <= s_k0;
      stub0_nlay_o  <= s_n0;
      stub1_valid_o <= s_v1;
      stub1_key_o   <= s_k1;
      stub1_nlay_o  <= s_n1;
      bx_o          <= bx_in_q;
    end
  end

  assert_stub1_needs_stub0_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    stub1_valid_o |-> stub0_valid_o);
  assert_key_gap_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stub0_valid_o && stub1_valid_o) |->
      (int'(stub1_key_o) > int'(stub0_key_o) + 2 || int'(stub0_key_o) > int'(stub1_key_o) + 2));
  assert_rank_order_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    stub1_valid_o |-> stub1_nlay_o <= stub0_nlay_o);
  assert_confirm_min_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    stub0_valid_o |-> stub0_nlay_o >= $past(confirm_thr_i));
  assert_pretrig_cover_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    stub0_valid_o |-> pretrig_o);
  assert_key_range_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    stub0_valid_o |-> int'(stub0_key_o) < NWG);
  assert_bx_step_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bx_o != '0) |-> bx_o == $past(bx_o) + BXW'(1));
endmodule

// File: tb/test_awg_stub_finder.sv
module test_awg_stub_finder;
  localparam int CLK_PERIOD = 10;
  localparam int NWG = 112;
  localparam int SW  = 2;
  localparam int BXW = 12;
  localparam int KW  = $clog2(NWG);
  localparam logic [7:0] NO = 8'hFF;

  typedef logic [0:5][7:0] trk_t;
  typedef struct packed {
    trk_t       ta;
    trk_t       tb;
    logic       pre;
    logic       v0;
    logic [7:0] k0;
    logic [2:0] n0;
    logic       v1;
    logic [7:0] k1;
    logic [2:0] n1;
  } vec_t;

  localparam trk_t NONE = {6{NO}};

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{ {6{8'd50}},  NONE,        1'b1, 1'b1, 8'd50,  3'd6, 1'b0, 8'd0,   3'd0 },
    '{ {6{8'd20}},  {6{8'd80}},  1'b1, 1'b1, 8'd20,  3'd6, 1'b1, 8'd80,  3'd6 },
    '{ {6{8'd80}},  {8'd20,8'd20,8'd20,8'd20,NO,NO},
                                 1'b1, 1'b1, 8'd80,  3'd6, 1'b1, 8'd20,  3'd4 },
    '{ {8'd30,8'd30,8'd30,NO,NO,NO}, NONE,
                                 1'b1, 1'b0, 8'd0,   3'd0, 1'b0, 8'd0,   3'd0 },
    '{ {6{8'd0}},   NONE,        1'b1, 1'b1, 8'd0,   3'd6, 1'b0, 8'd0,   3'd0 },
    '{ {6{8'd111}}, NONE,        1'b1, 1'b1, 8'd111, 3'd6, 1'b0, 8'd0,   3'd0 },
    '{ {8'd58,8'd59,8'd60,8'd61,8'd62,8'd62}, NONE,
                                 1'b1, 1'b1, 8'd60,  3'd6, 1'b0, 8'd0,   3'd0 },
    '{ {8'd62,8'd61,8'd60,8'd59,8'd58,8'd58}, NONE,
                                 1'b1, 1'b0, 8'd0,   3'd0, 1'b0, 8'd0,   3'd0 },
    '{ NONE,        NONE,        1'b0, 1'b0, 8'd0,   3'd0, 1'b0, 8'd0,   3'd0 },
    '{ {8'd10,8'd10,8'd10,8'd10,8'd10,NO}, {NO,8'd100,8'd100,8'd100,8'd100,8'd100},
                                 1'b1, 1'b1, 8'd10,  3'd5, 1'b1, 8'd100, 3'd5 }
  };

  logic              clk;
  logic              rst_n;
  logic [6*NWG-1:0]  hits;
  logic [2:0]        pre_thr, conf_thr;
  logic [SW-1:0]     stretch;
  logic              pre_o, v0, v1;
  logic [KW-1:0]     k0, k1;
  logic [2:0]        n0, n1;
  logic [BXW-1:0]    bx;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  awg_stub_finder #(.NWG(NWG), .SW(SW), .BXW(BXW)) i_awg_stub_finder (
    .clk(clk), .rst_n(rst_n), .hits_i(hits),
    .pretrig_thr_i(pre_thr), .confirm_thr_i(conf_thr), .stretch_i(stretch),
    .pretrig_o(pre_o),
    .stub0_valid_o(v0), .stub0_key_o(k0), .stub0_nlay_o(n0),
    .stub1_valid_o(v1), .stub1_key_o(k1), .stub1_nlay_o(n1),
    .bx_o(bx)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [6*NWG-1:0] mk(input trk_t a, input trk_t b);
    logic [6*NWG-1:0] r;
    r = '0;
    for (int l = 0; l < 6; l++) begin
      if (a[l] != NO) r[l*NWG + int'(a[l])] = 1'b1;
      if (b[l] != NO) r[l*NWG + int'(b[l])] = 1'b1;
    end
    return r;
  endfunction

  task automatic idle(input int n);
    hits = '0;
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int bx_a;
    rst_n    = 1'b0;
    hits     = mk({6{8'd50}}, NONE);
    pre_thr  = 3'd2;
    conf_thr = 3'd4;
    stretch  = SW'(1);
    @(negedge clk);
    tick(); tick(); tick();
    // R1: nothing comes out during reset despite a full track on the input
    chk("R1 reset stub0 valid", int'(v0), 0);
    chk("R1 reset stub1 valid", int'(v1), 0);
    chk("R1 reset pretrig", int'(pre_o), 0);
    chk("R1 reset key", int'(k0), 0);
    chk("R1 reset bx", int'(bx), 0);
    hits  = '0;
    rst_n = 1'b1;
    idle(6);
    chk("R1 after release stub0 valid", int'(v0), 0);

    // Table: one crossing of hits, then a check two crossings later
    for (int i = 0; i < NVEC; i++) begin
      string t;
      t = (i == 4 || i == 5) ? "R3" : "R2";
      hits = mk(VECS[i].ta, VECS[i].tb);
      tick();
      hits = '0;
      tick();
      chk($sformatf("R5 vec %0d pretrig", i), int'(pre_o), int'(VECS[i].pre));
      chk($sformatf("R4 vec %0d stub0 valid", i), int'(v0), int'(VECS[i].v0));
      if (VECS[i].v0) begin
        chk($sformatf("R6 %s vec %0d stub0 key", t, i), int'(k0), int'(VECS[i].k0));
        chk($sformatf("R6 %s vec %0d stub0 layers", t, i), int'(n0), int'(VECS[i].n0));
      end
      chk($sformatf("R7 vec %0d stub1 valid", i), int'(v1), int'(VECS[i].v1));
      if (VECS[i].v1) begin
        chk($sformatf("R7 vec %0d stub1 key", i), int'(k1), int'(VECS[i].k1));
        chk($sformatf("R7 vec %0d stub1 layers", i), int'(n1), int'(VECS[i].n1));
      end
      tick();
    end

    // R7: exclusion zone, low confirm threshold
    conf_thr = 3'd2;
    idle(2);
    hits = mk({6{8'd50}}, {NO,NO,NO,NO,8'd55,8'd55});
    tick(); hits = '0; tick();
    chk("R7 gap3 stub0 key", int'(k0), 50);
    chk("R7 gap3 stub1 valid", int'(v1), 1);
    chk("R7 gap3 stub1 key", int'(k1), 53);
    chk("R7 gap3 stub1 layers", int'(n1), 2);
    idle(2);
    hits = mk({6{8'd50}}, NONE);
    tick(); hits = '0; tick();
    chk("R7 near neighbours excluded stub1 valid", int'(v1), 0);
    chk("R7 near neighbours stub0 layers", int'(n0), 6);

    // R4: pre-trigger threshold gates confirmation
    conf_thr = 3'd4;
    pre_thr  = 3'd5;
    idle(2);
    hits = mk({8'd20,8'd20,8'd20,8'd20,NO,NO}, NONE);
    tick(); hits = '0; tick();
    chk("R4 high pretrig blocks stub", int'(v0), 0);
    chk("R5 pretrig low at 4 layers thr 5", int'(pre_o), 0);
    pre_thr = 3'd4;
    idle(2);
    hits = mk({8'd20,8'd20,8'd20,8'd20,NO,NO}, NONE);
    tick(); hits = '0; tick();
    chk("R4 equal threshold stub valid", int'(v0), 1);
    chk("R4 equal threshold layers", int'(n0), 4);
    pre_thr = 3'd2;

    // R8: stretch of 3 merges layers two crossings apart
    stretch = SW'(3);
    idle(6);
    hits = mk({8'd40,8'd40,NO,NO,NO,NO}, NONE); tick();
    hits = '0; tick();
    hits = mk({NO,NO,8'd40,8'd40,NO,NO}, NONE); tick();
    hits = '0;
    chk("R8 stretch3 m3 no stub", int'(v0), 0);
    chk("R5 stretch3 m3 pretrig", int'(pre_o), 1);
    tick();
    chk("R8 stretch3 m4 stub valid", int'(v0), 1);
    chk("R8 stretch3 m4 key", int'(k0), 40);
    chk("R8 stretch3 m4 layers", int'(n0), 4);
    tick();
    chk("R8 stretch3 m5 no stub", int'(v0), 0);

    // R8: stretch of 1 never merges them
    stretch = SW'(1);
    idle(6);
    hits = mk({8'd40,8'd40,NO,NO,NO,NO}, NONE); tick();
    hits = '0; tick();
    hits = mk({NO,NO,8'd40,8'd40,NO,NO}, NONE); tick();
    hits = '0;
    chk("R8 stretch1 m3 no stub", int'(v0), 0);
    tick();
    chk("R8 stretch1 m4 no stub", int'(v0), 0);
    tick();
    chk("R8 stretch1 m5 no stub", int'(v0), 0);

    // R9: crossing numbers of two results five crossings apart
    idle(3);
    hits = mk({6{8'd70}}, NONE); tick();
    hits = '0; tick();
    chk("R9 first stub valid", int'(v0), 1);
    bx_a = int'(bx);
    tick();
    chk("R2 one-crossing pulse leaves no stub", int'(v0), 0);
    tick(); tick();
    hits = mk({6{8'd70}}, NONE); tick();
    hits = '0; tick();
    chk("R9 second stub valid", int'(v0), 1);
    chk("R9 crossing spacing", (int'(bx) - bx_a + (1 << BXW)) % (1 << BXW), 5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule